// File: doc/BRIEF.md
# Interrupt Acceptance and Flag Controller

This block holds the processor status word and decides, cycle by cycle, whether a pending interrupt is taken. A hardware requester presents a 3-bit priority and an interrupt number on a valid/ready channel. A software-interrupt channel presents an interrupt number on its own valid/ready pair. A plain write port lets the core overwrite the whole status word. When a request is taken, the block updates the control part of the status word. In the same edge it loads a one-entry output record with three items: the status word as it stood before acceptance, the interrupt number and the 20-bit address of the vector-table entry.

The status word is 11 bits. Bit 0 is carry, bit 1 debug, bit 2 zero, bit 3 sign, bit 4 register-bank select and bit 5 overflow; these six are never altered by acceptance. Bit 6 is the interrupt enable, bit 7 is the stack select, and bits 10:8 hold the current priority level. The vector-table base arrives as a 4-bit upper part and a 16-bit lower part.

Back-pressure rules: a requester holds valid and its payload until it sees ready high at a clock edge, and the transfer happens on that edge. The output record is offered with `take_valid` and stays stable until the edge where `take_ready` is high. While a record waits, both input readies are low and nothing is accepted. When `take_ready` is high, a new request can be accepted on the same edge that retires the waiting record.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset, the status word is 0, `take_valid` is 0, `sw_ready` is 1 and `hw_ready` is 0.
- R2: A hardware request is accepted only when all four conditions hold: the enable bit (bit 6) is 1, `hw_prio` is strictly greater than the level in bits 10:8, no software request is valid, and the output slot is free.
- R3: On the edge that accepts a hardware request, bit 6 and bit 7 become 0 and bits 10:8 take the accepted `hw_prio`.
- R4: A software request is accepted whenever the output slot is free, whatever the enable bit and the level. While `sw_valid` is high, `hw_ready` is low.
- R5: A software acceptance clears bit 6 and leaves bits 10:8 unchanged. It clears bit 7 when the number is below 32 and leaves bit 7 unchanged when the number is 32 or more.
- R6: Acceptance of either kind leaves bits 5:0 unchanged.
- R7: After an acceptance edge, `take_valid` is 1 and `take_saved` holds the status word from before that edge. `take_num` holds the number and `take_sw` is 1 for a software request, 0 for a hardware one. `take_addr` equals {`tbl_hi`,`tbl_lo`} + 4 × number, modulo 2^20.
- R8: While `take_valid` is 1 and `take_ready` is 0, the record stays unchanged and both `sw_ready` and `hw_ready` are low.
- R9: With `flag_wr_en` high and no acceptance in that cycle, the status word becomes `flag_wr_data` on the edge. A write in the same cycle as an acceptance is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_valid | input | 1 | Software interrupt request present |
| sw_ready | output | 1 | Software request taken on this edge if valid |
| sw_num | input | 8 | Software interrupt number |
| hw_valid | input | 1 | Hardware interrupt request present |
| hw_ready | output | 1 | Hardware request taken on this edge if valid |
| hw_prio | input | 3 | Hardware request priority |
| hw_num | input | 8 | Hardware interrupt number |
| flag_wr_en | input | 1 | Status word write strobe |
| flag_wr_data | input | 11 | Status word write value |
| tbl_hi | input | 4 | Vector-table base, upper bits |
| tbl_lo | input | 16 | Vector-table base, lower bits |
| flags | output | 11 | Current status word |
| take_valid | output | 1 | Acceptance record valid |
| take_ready | input | 1 | Consumer takes the record |
| take_addr | output | 20 | Vector-table entry address |
| take_saved | output | 11 | Status word before acceptance |
| take_sw | output | 1 | Record came from the software channel |
| take_num | output | 8 | Accepted interrupt number |

## Verification
Every cycle, the assertions check five things: the gating of hardware acceptance on enable and strict priority, the flag updates that follow each kind of acceptance, the untouched arithmetic bits, the contents of the record, and the frozen record and closed readies under back-pressure. Only the bench's scenarios can show certain outcomes. These are a rejection when the priority equals the level, the exact 31/32 boundary of the stack-select rule, address wrap-around past 2^20, a write that loses to a same-cycle acceptance, and a software request winning over a hardware request presented in the same cycle.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int FLAG_W    = 11;
  localparam int ARITH_W   = 6;
  localparam int EN_BIT    = 6;
  localparam int STK_BIT   = 7;
  localparam int LVL_LSB   = 8;
  localparam int LVL_W     = 3;
  localparam int LVL_MSB   = LVL_LSB + LVL_W - 1;

  typedef enum logic {
    SRC_HW = 1'b0,
    SRC_SW = 1'b1
  } irq_src_e;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_accept_pkg::*;
#(
  parameter int PRIO_W    = 3,
  parameter int NUM_W     = 8,
  parameter int STK_LIMIT = 32
) (
  input  logic              sw_valid,
  input  logic [NUM_W-1:0]  sw_num,
  input  logic              hw_valid,
  input  logic [PRIO_W-1:0] hw_prio,
  input  logic [NUM_W-1:0]  hw_num,
  input  logic              int_en,
  input  logic [PRIO_W-1:0] cur_lvl,
  input  logic              slot_free,
  output logic              sw_ready,
  output logic              hw_ready,
  output logic              take,
  output irq_src_e          take_src,
  output logic [NUM_W-1:0]  take_num,
  output logic [PRIO_W-1:0] take_prio,
  output logic              clr_stack
);
  logic hw_eligible;
  logic take_sw_c;
  logic take_hw_c;
  logic sw_low_num;

  // hardware gating: enabled and strictly above the current level
  assign hw_eligible = int_en && (hw_prio > cur_lvl);

  // software channel wins whenever it is valid
  assign sw_ready  = slot_free;
  assign hw_ready  = slot_free && !sw_valid && hw_eligible;

  assign take_sw_c = sw_valid && sw_ready;
  assign take_hw_c = hw_valid && hw_ready;
  assign sw_low_num = int'(sw_num) < STK_LIMIT;

  always_comb begin
    take      = take_sw_c || take_hw_c;
    take_src  = take_sw_c ? SRC_SW : SRC_HW;
    take_num  = take_sw_c ? sw_num : hw_num;
    take_prio = hw_prio;
    clr_stack = take_hw_c || (take_sw_c && sw_low_num);
  end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irq_accept_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  input  logic              take,
  input  irq_src_e          take_src,
  input  logic [PRIO_W-1:0] take_prio,
  input  logic              clr_stack,
  output logic [FLAG_W-1:0] flags_q
);
  logic [FLAG_W-1:0] flags_d;

  always_comb begin
    flags_d = flags_q;
    if (take) begin
      flags_d[EN_BIT] = 1'b0;
      if (clr_stack) flags_d[STK_BIT] = 1'b0;
      if (take_src == SRC_HW) flags_d[LVL_MSB:LVL_LSB] = take_prio;
    end else if (wr_en) begin
      flags_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
  parameter int NUM_W = 8,
  parameter int HI_W  = 4,
  parameter int LO_W  = 16
) (
  input  logic [HI_W-1:0]      tbl_hi,
  input  logic [LO_W-1:0]      tbl_lo,
  input  logic [NUM_W-1:0]     num,
  output logic [HI_W+LO_W-1:0] addr
);
  localparam int ADDR_W = HI_W + LO_W;
  localparam int PAD_W  = ADDR_W - NUM_W - 2;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offset;

  // each table entry is four bytes wide; the sum wraps at 2^ADDR_W
  assign base   = {tbl_hi, tbl_lo};
  assign offset = {{PAD_W{1'b0}}, num, 2'b00};
  assign addr   = base + offset;
endmodule

// File: rtl/irq_out_slot.sv
module irq_out_slot
  import irq_accept_pkg::*;
#(
  parameter int NUM_W  = 8,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [FLAG_W-1:0] load_saved,
  input  irq_src_e          load_src,
  input  logic [NUM_W-1:0]  load_num,
  input  logic              out_ready,
  output logic              slot_free,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [FLAG_W-1:0] out_saved,
  output logic              out_sw,
  output logic [NUM_W-1:0]  out_num
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_saved <= '0;
      out_sw    <= 1'b0;
      out_num   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_addr  <= load_addr;
      out_saved <= load_saved;
      out_sw    <= (load_src == SRC_SW);
      out_num   <= load_num;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int NUM_W     = 8,
  parameter int HI_W      = 4,
  parameter int LO_W      = 16,
  parameter int STK_LIMIT = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sw_valid,
  output logic                  sw_ready,
  input  logic [NUM_W-1:0]      sw_num,
  input  logic                  hw_valid,
  output logic                  hw_ready,
  input  logic [LVL_W-1:0]      hw_prio,
  input  logic [NUM_W-1:0]      hw_num,
  input  logic                  flag_wr_en,
  input  logic [FLAG_W-1:0]     flag_wr_data,
  input  logic [HI_W-1:0]       tbl_hi,
  input  logic [LO_W-1:0]       tbl_lo,
  output logic [FLAG_W-1:0]     flags,
  output logic                  take_valid,
  input  logic                  take_ready,
  output logic [HI_W+LO_W-1:0]  take_addr,
  output logic [FLAG_W-1:0]     take_saved,
  output logic                  take_sw,
  output logic [NUM_W-1:0]      take_num
);
  localparam int ADDR_W = HI_W + LO_W;

  logic              slot_free;
  logic              take;
  irq_src_e          take_src;
  logic [NUM_W-1:0]  sel_num;
  logic [LVL_W-1:0]  sel_prio;
  logic              clr_stack;
  logic [ADDR_W-1:0] vec_addr;

  irq_arbiter #(
    .PRIO_W   (LVL_W),
    .NUM_W    (NUM_W),
    .STK_LIMIT(STK_LIMIT)
  ) u_arb (
    .sw_valid (sw_valid),
    .sw_num   (sw_num),
    .hw_valid (hw_valid),
    .hw_prio  (hw_prio),
    .hw_num   (hw_num),
    .int_en   (flags[EN_BIT]),
    .cur_lvl  (flags[LVL_MSB:LVL_LSB]),
    .slot_free(slot_free),
    .sw_ready (sw_ready),
    .hw_ready (hw_ready),
    .take     (take),
    .take_src (take_src),
    .take_num (sel_num),
    .take_prio(sel_prio),
    .clr_stack(clr_stack)
  );

  irq_flag_reg #(
    .PRIO_W(LVL_W)
  ) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (flag_wr_en),
    .wr_data  (flag_wr_data),
    .take     (take),
    .take_src (take_src),
    .take_prio(sel_prio),
    .clr_stack(clr_stack),
    .flags_q  (flags)
  );

  irq_vec_gen #(
    .NUM_W(NUM_W),
    .HI_W (HI_W),
    .LO_W (LO_W)
  ) u_vec (
    .tbl_hi(tbl_hi),
    .tbl_lo(tbl_lo),
    .num   (sel_num),
    .addr  (vec_addr)
  );

  irq_out_slot #(
    .NUM_W (NUM_W),
    .ADDR_W(ADDR_W)
  ) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take),
    .load_addr (vec_addr),
    .load_saved(flags),
    .load_src  (take_src),
    .load_num  (sel_num),
    .out_ready (take_ready),
    .slot_free (slot_free),
    .out_valid (take_valid),
    .out_addr  (take_addr),
    .out_saved (take_saved),
    .out_sw    (take_sw),
    .out_num   (take_num)
  );
endmodule

// File: rtl/irq_accept_ctrl_chk.sv
module irq_accept_ctrl_chk
  import irq_accept_pkg::*;
#(
  parameter int NUM_W     = 8,
  parameter int HI_W      = 4,
  parameter int LO_W      = 16,
  parameter int STK_LIMIT = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sw_valid,
  input logic                  sw_ready,
  input logic [NUM_W-1:0]      sw_num,
  input logic                  hw_valid,
  input logic                  hw_ready,
  input logic [LVL_W-1:0]      hw_prio,
  input logic [NUM_W-1:0]      hw_num,
  input logic                  flag_wr_en,
  input logic [FLAG_W-1:0]     flag_wr_data,
  input logic [HI_W-1:0]       tbl_hi,
  input logic [LO_W-1:0]       tbl_lo,
  input logic [FLAG_W-1:0]     flags,
  input logic                  take_valid,
  input logic                  take_ready,
  input logic [HI_W+LO_W-1:0]  take_addr,
  input logic [FLAG_W-1:0]     take_saved,
  input logic                  take_sw,
  input logic [NUM_W-1:0]      take_num
);
  localparam int ADDR_W = HI_W + LO_W;
  localparam int PAD_W  = ADDR_W - NUM_W - 2;

  logic              sw_hs;
  logic              hw_hs;
  logic              any_hs;
  logic [NUM_W-1:0]  hs_num;
  logic [ADDR_W-1:0] exp_addr;

  assign sw_hs    = sw_valid && sw_ready;
  assign hw_hs    = hw_valid && hw_ready;
  assign any_hs   = sw_hs || hw_hs;
  assign hs_num   = sw_hs ? sw_num : hw_num;
  assign exp_addr = {tbl_hi, tbl_lo} + {{PAD_W{1'b0}}, hs_num, 2'b00};

  assert_hw_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hw_hs |-> (flags[EN_BIT] && (hw_prio > flags[LVL_MSB:LVL_LSB])));

  assert_hw_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_hs |=> (!flags[EN_BIT] && !flags[STK_BIT] &&
               flags[LVL_MSB:LVL_LSB] == $past(hw_prio)));

  assert_sw_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_valid |-> !hw_ready);

  assert_sw_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hs |=> (!flags[EN_BIT] &&
               flags[LVL_MSB:LVL_LSB] == $past(flags[LVL_MSB:LVL_LSB]) &&
               flags[STK_BIT] == ((int'($past(sw_num)) < STK_LIMIT) ? 1'b0
                                  : $past(flags[STK_BIT]))));

  assert_arith_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_hs |=> flags[ARITH_W-1:0] == $past(flags[ARITH_W-1:0]));

  assert_record_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_hs |=> (take_valid && take_saved == $past(flags) &&
                take_addr == $past(exp_addr) && take_num == $past(hs_num) &&
                take_sw == $past(sw_hs)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && !take_ready) |=> (take_valid && $stable(take_addr) &&
                                     $stable(take_saved) && $stable(take_num) &&
                                     $stable(take_sw)));

  assert_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && !take_ready) |-> (!sw_ready && !hw_ready));

  assert_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_en && !any_hs) |=> flags == $past(flag_wr_data));
endmodule

bind irq_accept_ctrl irq_accept_ctrl_chk #(
  .NUM_W    (NUM_W),
  .HI_W     (HI_W),
  .LO_W     (LO_W),
  .STK_LIMIT(STK_LIMIT)
) u_chk (.*);

// File: tb/irq_accept_ctrl_test.sv
`timescale 1ns/1ps
module irq_accept_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_valid, sw_ready, hw_valid, hw_ready;
  logic [7:0]  sw_num, hw_num, take_num;
  logic [2:0]  hw_prio;
  logic        flag_wr_en;
  logic [10:0] flag_wr_data, flags, take_saved;
  logic [3:0]  tbl_hi;
  logic [15:0] tbl_lo;
  logic        take_valid, take_ready, take_sw;
  logic [19:0] take_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_accept_ctrl uut (.*);

  function automatic logic [10:0] fw(input logic [2:0] lvl, input logic stk,
                                     input logic en, input logic [5:0] ar);
    return {lvl, stk, en, ar};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sw_valid = 0; sw_num = 0; hw_valid = 0; hw_prio = 0; hw_num = 0;
    flag_wr_en = 0; flag_wr_data = 0; take_ready = 1;
  endtask

  task automatic write_flags(input logic [10:0] w);
    @(negedge clk); flag_wr_en = 1; flag_wr_data = w;
    @(posedge clk); #1 flag_wr_en = 0;
    chk("R9 write", flags, w);
  endtask

  task automatic t_reset();
    idle(); tbl_hi = 4'h1; tbl_lo = 16'h2000;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk("R1 flags", flags, 0);
    chk("R1 take_valid", take_valid, 0);
    chk("R1 sw_ready", sw_ready, 1);
    chk("R1 hw_ready", hw_ready, 0);
  endtask

  task automatic t_hw_gate();
    write_flags(fw(3'd3, 1'b0, 1'b0, 6'h00));
    @(negedge clk); hw_valid = 1; hw_prio = 3'd7; hw_num = 8'h11; #1;
    chk("R2 disabled", hw_ready, 0);
    @(posedge clk); #1 hw_valid = 0;
    chk("R2 no take", take_valid, 0);
    write_flags(fw(3'd3, 1'b1, 1'b1, 6'h2D));
    @(negedge clk); hw_valid = 1; hw_prio = 3'd3; #1;
    chk("R2 equal level", hw_ready, 0);
    hw_prio = 3'd4; #1;
    chk("R2 higher level", hw_ready, 1);
    @(posedge clk); #1 hw_valid = 0;
    chk("R3 R6 flags", flags, fw(3'd4, 1'b0, 1'b0, 6'h2D));
    chk("R7 valid", take_valid, 1);
    chk("R7 sw", take_sw, 0);
    chk("R7 num", take_num, 8'h11);
    chk("R7 saved", take_saved, fw(3'd3, 1'b1, 1'b1, 6'h2D));
    chk("R7 addr", take_addr, 20'h12044);
    @(posedge clk); #1;
    chk("R7 retire", take_valid, 0);
  endtask

  task automatic t_sw_num(input logic [7:0] n, input logic [10:0] pre,
                          input logic [10:0] post);
    write_flags(pre);
    @(negedge clk); sw_valid = 1; sw_num = n; #1;
    chk("R4 sw_ready", sw_ready, 1);
    @(posedge clk); #1 sw_valid = 0;
    chk("R5 R6 flags", flags, post);
    chk("R7 sw", take_sw, 1);
    chk("R7 saved", take_saved, pre);
    chk("R7 addr", take_addr, 20'h12000 + {10'd0, n, 2'b00});
  endtask

  task automatic t_precedence();
    write_flags(fw(3'd0, 1'b1, 1'b1, 6'h00));
    @(negedge clk); hw_valid = 1; hw_prio = 3'd6; hw_num = 8'h03;
    sw_valid = 1; sw_num = 8'd50; #1;
    chk("R4 hw blocked", hw_ready, 0);
    chk("R4 sw open", sw_ready, 1);
    @(posedge clk); #1 sw_valid = 0;
    chk("R4 winner", take_num, 8'd50);
    chk("R4 level kept", flags, fw(3'd0, 1'b1, 1'b0, 6'h00));
    @(negedge clk); hw_valid = 0;
  endtask

  task automatic t_backpressure();
    write_flags(fw(3'd0, 1'b0, 1'b1, 6'h00));
    @(negedge clk); take_ready = 0; sw_valid = 1; sw_num = 8'd2;
    @(posedge clk); #1 sw_num = 8'd9;
    chk("R8 first", take_num, 8'd2);
    chk("R8 sw closed", sw_ready, 0);
    chk("R8 hw closed", hw_ready, 0);
    @(posedge clk); #1;
    chk("R8 held valid", take_valid, 1);
    chk("R8 held num", take_num, 8'd2);
    chk("R8 held addr", take_addr, 20'h12008);
    take_ready = 1; #1;
    chk("R8 reopen", sw_ready, 1);
    @(posedge clk); #1 sw_valid = 0;
    chk("R8 next", take_num, 8'd9);
  endtask

  task automatic t_wrap();
    tbl_hi = 4'hF; tbl_lo = 16'hFFF0;
    @(negedge clk); sw_valid = 1; sw_num = 8'h10;
    @(posedge clk); #1 sw_valid = 0;
    chk("R7 wrap", take_addr, 20'h00030);
    tbl_hi = 4'h1; tbl_lo = 16'h2000;
  endtask

  task automatic t_write_conflict();
    write_flags(fw(3'd0, 1'b1, 1'b1, 6'h00));
    @(negedge clk); flag_wr_en = 1; flag_wr_data = 11'h7FF;
    hw_valid = 1; hw_prio = 3'd1; hw_num = 8'h01;
    @(posedge clk); #1 flag_wr_en = 0; hw_valid = 0;
    chk("R9 write lost", flags, fw(3'd1, 1'b0, 1'b0, 6'h00));
    @(posedge clk); #1;
    chk("R9 steady", flags, fw(3'd1, 1'b0, 1'b0, 6'h00));
  endtask

  initial begin
    t_reset();
    t_hw_gate();
    t_sw_num(8'd5,  fw(3'd5, 1'b1, 1'b0, 6'h00), fw(3'd5, 1'b0, 1'b0, 6'h00));
    t_sw_num(8'd31, fw(3'd2, 1'b1, 1'b1, 6'h3F), fw(3'd2, 1'b0, 1'b0, 6'h3F));
    t_sw_num(8'd32, fw(3'd2, 1'b1, 1'b1, 6'h3F), fw(3'd2, 1'b1, 1'b0, 6'h3F));
    t_sw_num(8'd40, fw(3'd6, 1'b1, 1'b1, 6'h15), fw(3'd6, 1'b1, 1'b0, 6'h15));
    t_precedence();
    t_backpressure();
    t_wrap();
    t_write_conflict();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule